// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. It is clocked by a reference oscillator that runs faster than the nominal tick rate. On every enabled reference cycle, a programmable 32-bit addend is summed into a 32-bit fractional accumulator. Each carry out of that sum advances the time value by a programmable tick period in nanoseconds.

The nominal addend is the ceiling of 2^32 divided by R. R is the ratio of oscillator frequency to nominal tick frequency and must be greater than one. Software trims the frequency while the timer runs by rewriting the addend with the base value plus or minus base × ppb / 10^9. A bypass mode skips the accumulator and advances the count on every reference cycle.

A synchronous register bus with separate read and write strobes gives access to the following:
- the control word and the addend;
- the fractional accumulator;
- the two count halves;
- a 64-bit offset that is added to the published time;
- a prescaler that divides the tick stream into a square output clock.

Count and offset are 64 bits wide, so both move through 32-bit words. Software writes the low word first, then the high word, and reads the low word first, then the high word.

Top module: `ntc_time_counter`

## Requirements
- R1: After reset, `time_ns` is 0, `clk_out` is 0 and every register (word addresses 0 to 7) reads 0.
- R2: With enable set (control bit 2) and bypass clear (control bit 3), each reference cycle adds the addend (address 1) into the 32-bit accumulator. Each carry out adds the tick period (control bits 25:16, nanoseconds) to the count, so n cycles from a zero accumulator advance it by period × floor(n × addend / 2^32).
- R3: With enable and bypass set, the count advances by the tick period on every reference cycle, carrying across the 32-bit word boundary, while the accumulator holds.
- R4: With enable clear, the count, the accumulator and `clk_out` hold, and register writes still take effect and read back.
- R5: Writing control with bit 5 set clears the count, the accumulator, the prescaler phase and `clk_out` at that same edge. The other written control fields take effect, and bit 5 reads back as 0.
- R6: A write to the count low word (address 3) is only staged and leaves the count unchanged. A write to the count high word (address 4) loads {high, staged low} at that edge and overrides that cycle's advance.
- R7: A read of the count low word returns the live low half and captures the live high half. A later read of the high word returns that captured half, even if the count has carried meanwhile.
- R8: An addend rewrite while running takes effect from the next cycle and keeps the accumulator's fractional state, so the time is the sum of the carries under each addend.
- R9: The accumulator (address 2) can be read and written. A write overrides that cycle's addition and produces no carry in that cycle.
- R10: `time_ns` equals the count plus the 64-bit offset, modulo 2^64. The offset low word (address 5) is staged, and a write to the high word (address 6) commits both halves.
- R11: `clk_out` toggles after every P advances of the count, where P is the prescale field at address 7, bits 15:0, and 0 acts as 1.
- R12: Read data is registered at the edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | 64 | Count plus offset in nanoseconds |
| clk_out | output | 1 | Prescaled tick clock |

## Verification
Every bus operation acts at the edge that samples its strobe:
- a count, accumulator, control or offset write is visible on `time_ns` or `clk_out` just after that edge;
- read data appears after the edge that samples the read;
- the first advance after enabling falls one edge after the enabling write.

The bench drives at the falling edge and samples at the next falling edge. It counts how many rising edges lie between a soft-reset or enabling write and each check, and derives the expected carries from that edge count. For the write that disables the timer, the bench accounts for the one last advance it still makes. It also places its coherent-read probe so that a carry into the high word falls between the two word reads.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    typedef enum logic [2:0] {
        REG_CTRL     = 3'd0,
        REG_ADDEND   = 3'd1,
        REG_ACC      = 3'd2,
        REG_CNT_LO   = 3'd3,
        REG_CNT_HI   = 3'd4,
        REG_OFF_LO   = 3'd5,
        REG_OFF_HI   = 3'd6,
        REG_PRESCALE = 3'd7
    } ntc_reg_e;

    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_BYP_BIT  = 3;
    localparam int CTRL_SRST_BIT = 5;
    localparam int CTRL_PER_LSB  = 16;

endpackage

// File: rtl/ntc_rate.sv
module ntc_rate #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          byp,
    input  logic          clr,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic [AW-1:0] addend,
    output logic          tick,
    output logic [AW-1:0] acc_o
);

    typedef struct packed {
        logic [AW-1:0] acc;
    } rate_st_t;

    rate_st_t    s_d, s_q;
    logic [AW:0] sum;

    always_comb begin
        s_d  = s_q;
        sum  = {1'b0, s_q.acc} + {1'b0, addend};
        tick = 1'b0;
        if (clr) begin
            s_d.acc = '0;
        end else if (ld) begin
            s_d.acc = ld_val;
        end else if (en && !byp) begin
            s_d.acc = sum[AW-1:0];
        end
        if (en && !clr) begin
            tick = byp || (sum[AW] && !ld);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_o = s_q.acc;

endmodule

// File: rtl/ntc_prescale.sv
module ntc_prescale #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  logic [PS_W-1:0] div,
    output logic            clk_out
);

    typedef struct packed {
        logic [PS_W-1:0] cnt;
        logic            out;
    } ps_st_t;

    ps_st_t        s_d, s_q;
    logic [PS_W:0] div_eff;
    logic [PS_W:0] next_cnt;

    always_comb begin
        s_d      = s_q;
        div_eff  = (div == '0) ? {{PS_W{1'b0}}, 1'b1} : {1'b0, div};
        next_cnt = {1'b0, s_q.cnt} + {{PS_W{1'b0}}, 1'b1};
        if (clr) begin
            s_d = '0;
        end else if (tick) begin
            if (next_cnt >= div_eff) begin
                s_d.cnt = '0;
                s_d.out = ~s_q.out;
            end else begin
                s_d.cnt = next_cnt[PS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_out = s_q.out;

endmodule

// File: rtl/ntc_regs.sv
module ntc_regs
    import ntc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PER_W = 10,
    parameter int PS_W  = 16,
    localparam int TW   = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [TW-1:0]    cnt_i,
    input  logic [DW-1:0]    acc_i,
    output logic             en_o,
    output logic             byp_o,
    output logic [PER_W-1:0] per_o,
    output logic [DW-1:0]    addend_o,
    output logic [PS_W-1:0]  ps_o,
    output logic [TW-1:0]    off_o,
    output logic             clr_o,
    output logic             cnt_ld_o,
    output logic [TW-1:0]    cnt_ld_val_o,
    output logic             acc_ld_o,
    output logic [DW-1:0]    acc_ld_val_o
);

    typedef struct packed {
        logic             en;
        logic             byp;
        logic [PER_W-1:0] per;
        logic [DW-1:0]    addend;
        logic [PS_W-1:0]  ps;
        logic [TW-1:0]    off;
        logic [DW-1:0]    cnt_stage;
        logic [DW-1:0]    off_stage;
        logic [DW-1:0]    hi_snap;
        logic [DW-1:0]    rdata;
    } regs_st_t;

    regs_st_t      s_d, s_q;
    logic [DW-1:0] ctrl_word;

    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[CTRL_EN_BIT]             = s_q.en;
        ctrl_word[CTRL_BYP_BIT]            = s_q.byp;
        ctrl_word[CTRL_PER_LSB +: PER_W]   = s_q.per;
    end

    always_comb begin
        s_d          = s_q;
        clr_o        = 1'b0;
        cnt_ld_o     = 1'b0;
        acc_ld_o     = 1'b0;
        cnt_ld_val_o = {wdata, s_q.cnt_stage};
        acc_ld_val_o = wdata;

        if (wr_en) begin
            case (addr)
                REG_CTRL: begin
                    s_d.en  = wdata[CTRL_EN_BIT];
                    s_d.byp = wdata[CTRL_BYP_BIT];
                    s_d.per = wdata[CTRL_PER_LSB +: PER_W];
                    clr_o   = wdata[CTRL_SRST_BIT];
                end
                REG_ADDEND:   s_d.addend    = wdata;
                REG_ACC:      acc_ld_o      = 1'b1;
                REG_CNT_LO:   s_d.cnt_stage = wdata;
                REG_CNT_HI:   cnt_ld_o      = 1'b1;
                REG_OFF_LO:   s_d.off_stage = wdata;
                REG_OFF_HI:   s_d.off       = {wdata, s_q.off_stage};
                REG_PRESCALE: s_d.ps        = wdata[PS_W-1:0];
                default: ;
            endcase
        end

        if (rd_en) begin
            case (addr)
                REG_CTRL:     s_d.rdata = ctrl_word;
                REG_ADDEND:   s_d.rdata = s_q.addend;
                REG_ACC:      s_d.rdata = acc_i;
                REG_CNT_LO: begin
                    s_d.rdata   = cnt_i[DW-1:0];
                    s_d.hi_snap = cnt_i[TW-1:DW];
                end
                REG_CNT_HI:   s_d.rdata = s_q.hi_snap;
                REG_OFF_LO:   s_d.rdata = s_q.off[DW-1:0];
                REG_OFF_HI:   s_d.rdata = s_q.off[TW-1:DW];
                REG_PRESCALE: s_d.rdata = {{(DW-PS_W){1'b0}}, s_q.ps};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata    = s_q.rdata;
    assign en_o     = s_q.en;
    assign byp_o    = s_q.byp;
    assign per_o    = s_q.per;
    assign addend_o = s_q.addend;
    assign ps_o     = s_q.ps;
    assign off_o    = s_q.off;

endmodule

// File: rtl/ntc_time_counter.sv
module ntc_time_counter #(
    parameter int DW    = 32,
    parameter int PER_W = 10,
    parameter int PS_W  = 16,
    localparam int TW   = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [TW-1:0] time_ns,
    output logic          clk_out
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          s_d, s_q;
    logic             en_w, byp_w, clr_w, cnt_ld_w, acc_ld_w, tick_w;
    logic [PER_W-1:0] per_w;
    logic [DW-1:0]    addend_w, acc_w, acc_ld_val_w;
    logic [PS_W-1:0]  ps_w;
    logic [TW-1:0]    off_w, cnt_ld_val_w, cnt_w;

    ntc_regs #(.DW(DW), .PER_W(PER_W), .PS_W(PS_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .rd_en        (reg_rd),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .cnt_i        (cnt_w),
        .acc_i        (acc_w),
        .en_o         (en_w),
        .byp_o        (byp_w),
        .per_o        (per_w),
        .addend_o     (addend_w),
        .ps_o         (ps_w),
        .off_o        (off_w),
        .clr_o        (clr_w),
        .cnt_ld_o     (cnt_ld_w),
        .cnt_ld_val_o (cnt_ld_val_w),
        .acc_ld_o     (acc_ld_w),
        .acc_ld_val_o (acc_ld_val_w)
    );

    ntc_rate #(.AW(DW)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_w),
        .byp    (byp_w),
        .clr    (clr_w),
        .ld     (acc_ld_w),
        .ld_val (acc_ld_val_w),
        .addend (addend_w),
        .tick   (tick_w),
        .acc_o  (acc_w)
    );

    ntc_prescale #(.PS_W(PS_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_w),
        .tick    (tick_w),
        .div     (ps_w),
        .clk_out (clk_out)
    );

    always_comb begin
        s_d = s_q;
        if (clr_w) begin
            s_d.cnt = '0;
        end else if (cnt_ld_w) begin
            s_d.cnt = cnt_ld_val_w;
        end else if (tick_w) begin
            s_d.cnt = s_q.cnt + {{(TW-PER_W){1'b0}}, per_w};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_w   = s_q.cnt;
    assign time_ns = s_q.cnt + off_w;

endmodule

// File: rtl/ntc_checker.sv
module ntc_checker #(
    parameter int DW    = 32,
    parameter int PER_W = 10,
    localparam int TW   = 2 * DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             byp,
    input logic             clr,
    input logic             cnt_ld,
    input logic [TW-1:0]    cnt_ld_val,
    input logic [PER_W-1:0] per,
    input logic [TW-1:0]    cnt,
    input logic [DW-1:0]    acc,
    input logic             acc_ld,
    input logic [DW-1:0]    acc_ld_val,
    input logic             clk_out
);

    logic [TW-1:0] per_ext;
    assign per_ext = {{(TW-PER_W){1'b0}}, per};

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr && !cnt_ld) |=> $stable(cnt));

    p_acc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr && !acc_ld) |=> $stable(acc));

    p_clkout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(clk_out));

    p_soft_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && acc == '0 && !clk_out));

    p_bypass_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && byp && !clr && !cnt_ld) |=> (cnt == $past(cnt) + $past(per_ext)));

    p_bypass_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && byp && !clr && !acc_ld) |=> $stable(acc));

    p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cnt_ld) |=> (cnt == $past(cnt) || cnt == $past(cnt) + $past(per_ext)));

    p_count_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ld && !clr) |=> (cnt == $past(cnt_ld_val)));

    p_acc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && !clr) |=> (acc == $past(acc_ld_val)));

endmodule

bind ntc_time_counter ntc_checker #(.DW(DW), .PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_w),
    .byp        (byp_w),
    .clr        (clr_w),
    .cnt_ld     (cnt_ld_w),
    .cnt_ld_val (cnt_ld_val_w),
    .per        (per_w),
    .cnt        (cnt_w),
    .acc        (acc_w),
    .acc_ld     (acc_ld_w),
    .acc_ld_val (acc_ld_val_w),
    .clk_out    (clk_out)
);

// File: tb/test_ntc_time_counter.sv
`timescale 1ns/1ps
module test_ntc_time_counter;

    localparam logic [2:0] A_CTRL = 3'd0, A_ADD = 3'd1, A_ACC = 3'd2, A_CLO = 3'd3,
                           A_CHI = 3'd4, A_OLO = 3'd5, A_OHI = 3'd6, A_PS = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;
    logic        clk_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ntc_time_counter i_ntc_time_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .time_ns(time_ns), .clk_out(clk_out)
    );

    function automatic logic [31:0] mk_ctrl(input int per, input bit en, input bit byp, input bit srst);
        logic [31:0] w;
        w = '0;
        w[25:16] = per[9:0];
        w[2] = en;
        w[3] = byp;
        w[5] = srst;
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 time", time_ns, 64'd0);
        check("R1 clk_out", {63'd0, clk_out}, 64'd0);
        rd(A_CTRL, d);  check("R1 ctrl", {32'd0, d}, 64'd0);
        rd(A_ADD, d);   check("R1 addend", {32'd0, d}, 64'd0);
        rd(A_PS, d);    check("R1 prescale", {32'd0, d}, 64'd0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(8, 1, 1, 0));
        idle(20);
        check("R3 bypass count", time_ns, 64'd160);
        rd(A_ACC, d);
        check("R3 acc holds", {32'd0, d}, 64'd0);
    endtask

    task automatic t_disable();
        logic [63:0] snap;
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(8, 0, 0, 0));
        snap = time_ns;
        idle(10);
        check("R4 hold", time_ns, snap);
        wr(A_ADD, 32'h1234_5678);
        rd(A_ADD, d);
        check("R4 write accepted", {32'd0, d}, 64'h1234_5678);
    endtask

    task automatic t_accum(input logic [31:0] a, input int per, input int n);
        logic [63:0] prod;
        wr(A_CTRL, mk_ctrl(per, 0, 0, 0));
        wr(A_ADD, a);
        wr(A_CTRL, mk_ctrl(per, 1, 0, 1));
        check("R5 soft reset clears", time_ns, 64'd0);
        idle(n);
        prod = 64'(n) * {32'd0, a};
        check("R2 accum carries", time_ns, 64'(per) * (prod >> 32));
    endtask

    task automatic t_trim(input logic [31:0] a1, input logic [31:0] a2, input int n1, input int n2);
        logic [63:0] t1, t2;
        wr(A_CTRL, mk_ctrl(5, 0, 0, 0));
        wr(A_ADD, a1);
        wr(A_CTRL, mk_ctrl(5, 1, 0, 1));
        idle(n1);
        wr(A_ADD, a2);
        idle(n2);
        t1 = 64'(n1 + 1) * {32'd0, a1};
        t2 = {32'd0, t1[31:0]} + 64'(n2) * {32'd0, a2};
        check("R8 trim", time_ns, 64'd5 * ((t1 >> 32) + (t2 >> 32)));
    endtask

    task automatic t_count_rw();
        logic [63:0] snap;
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0));
        snap = time_ns;
        wr(A_CLO, 32'hFFFF_FFFE);
        check("R6 low staged only", time_ns, snap);
        wr(A_CHI, 32'd5);
        check("R6 high commits", time_ns, 64'h5_FFFF_FFFE);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 0));
        rd(A_CLO, d);
        check("R7 low word", {32'd0, d}, 64'hFFFF_FFFE);
        idle(1);
        rd(A_CHI, d);
        check("R7 captured high", {32'd0, d}, 64'd5);
        check("R3 word carry", time_ns, 64'h6_0000_0001);
        wr(A_CLO, 32'h100);
        wr(A_CHI, 32'd0);
        check("R6 load beats advance", time_ns, 64'h100);
        idle(1);
        check("R6 resumes", time_ns, 64'h101);
    endtask

    task automatic t_offset();
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0));
        wr(A_CLO, 32'd100);
        wr(A_CHI, 32'd0);
        wr(A_OLO, 32'hFFFF_FFFF);
        check("R10 offset staged", time_ns, 64'd100);
        wr(A_OHI, 32'd0);
        check("R10 offset sum", time_ns, 64'h1_0000_0063);
        rd(A_OLO, d);
        check("R10 offset readback", {32'd0, d}, 64'hFFFF_FFFF);
        wr(A_OHI, 32'hFFFF_FFFF);
        check("R10 wrap", time_ns, 64'd99);
        wr(A_OLO, 32'd0);
        wr(A_OHI, 32'd0);
        check("R10 cleared", time_ns, 64'd100);
    endtask

    task automatic t_accreg();
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(7, 0, 0, 0));
        wr(A_CLO, 32'd0);
        wr(A_CHI, 32'd0);
        wr(A_ACC, 32'hFFFF_FFFF);
        rd(A_ACC, d);
        check("R9 acc readback", {32'd0, d}, 64'hFFFF_FFFF);
        wr(A_ADD, 32'd1);
        wr(A_CTRL, mk_ctrl(7, 1, 0, 0));
        idle(1);
        check("R9 carry from loaded acc", time_ns, 64'd7);
        idle(3);
        check("R9 no further carry", time_ns, 64'd7);
        wr(A_ACC, 32'hFFFF_FFFF);
        check("R9 write overrides add", time_ns, 64'd7);
        idle(1);
        check("R9 carry after reload", time_ns, 64'd14);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0));
        wr(A_PS, 32'd3);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 1));
        check("R5 clk_out cleared", {63'd0, clk_out}, 64'd0);
        idle(2); check("R11 before 3 ticks", {63'd0, clk_out}, 64'd0);
        idle(1); check("R11 toggle at 3", {63'd0, clk_out}, 64'd1);
        idle(2); check("R11 hold", {63'd0, clk_out}, 64'd1);
        idle(1); check("R11 toggle at 6", {63'd0, clk_out}, 64'd0);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 0));
        wr(A_PS, 32'd0);
        wr(A_CTRL, mk_ctrl(1, 1, 1, 1));
        idle(1); check("R11 zero acts as one", {63'd0, clk_out}, 64'd1);
        idle(1); check("R11 zero acts as one b", {63'd0, clk_out}, 64'd0);
        rd(A_CTRL, d);
        check("R5 bit reads zero", {32'd0, d}, {32'd0, mk_ctrl(1, 1, 1, 0)});
    endtask

    task automatic t_readlat();
        logic [31:0] d;
        wr(A_ADD, 32'hCAFE_0001);
        rd(A_ADD, d);
        check("R12 read data", {32'd0, d}, 64'hCAFE_0001);
        idle(3);
        check("R12 read data holds", {32'd0, reg_rdata}, 64'hCAFE_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_disable();
        t_accum(32'h4000_0000, 10, 40);
        t_accum(32'hAAAA_AAAB, 5, 300);
        t_accum(32'hCCCC_CCCD, 5, 123);
        t_trim(32'h8000_0000, 32'h2000_0000, 9, 17);
        t_trim(32'hCCCC_CCCD, 32'hCCCD_5000, 50, 77);
        t_count_rw();
        t_offset();
        t_accreg();
        t_prescale();
        t_readlat();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule